// File: doc/BRIEF.md
# Two-Level Interrupt Cascade Acknowledger

This block combines two eight-line interrupt controller cores into one sixteen-line interrupt source for a CPU. The first core is the primary controller and the second is the secondary controller. Each core reports whether it has a pending line, which line that is, and its vector base. The block forwards the secondary core's request into input line 2 of the primary core as a short pulse, so the primary core's edge detector latches it. The CPU interrupt output follows the primary core's pending flag.

When the CPU strobes an acknowledge, the block sends in-service acknowledges to the primary core and, when the primary core picks line 2, to the secondary core as well. On the next clock edge it returns an 8-bit vector, a combined line number from 0 to 15 and a done pulse. A core with nothing pending gives line 7 as a spurious line. A separate status read polls the primary core and then, through line 2, the secondary core. It tells the cores to clear the lines it reports, and it tells the primary core to switch its register read selection to in-service. The cores' internal registers are not part of this block.

Top module: `cic_cascade_ack`

## Requirements
- R1: `casc_req` is high in a cycle only if `slv_pend` was high and `casc_req` was low in the cycle before. While `slv_pend` stays high, `casc_req` alternates high and low, starting high one cycle after `slv_pend` rises.
- R2: `cpu_int` equals `mst_pend` in every cycle, so it follows the new primary core state after each acknowledge.
- R3: An acknowledge while `mst_pend` is low issues no core acknowledge. On the next edge it returns line 7 and a vector of `mst_base`+7.
- R4: An acknowledge while the primary core reports a line other than 2 raises `mst_ack` with that line in the same cycle, and not `slv_ack`. It returns that line and a vector of `mst_base`+line.
- R5: An acknowledge while the primary core reports line 2 and `slv_pend` is high raises both `mst_ack` (line 2) and `slv_ack` (with the secondary line). It returns the secondary line+8 and a vector of `slv_base`+secondary line.
- R6: An acknowledge while the primary core reports line 2 and `slv_pend` is low raises `mst_ack` only. It returns line 15 and a vector of `slv_base`+7.
- R7: A status read while the primary core reports a line other than 2 raises `mst_clr` with that line in the same cycle, and not `slv_clr`. It returns that line.
- R8: A status read while `mst_pend` is low raises no clear and returns 7.
- R9: A status read while the primary core reports line 2 raises `mst_clr` for line 2. It also raises `slv_clr` for the secondary line if `slv_pend` is high. It returns the secondary line+8, or 15 if `slv_pend` is low.
- R10: Every status read that is accepted raises `mst_rsel_isr` in the same cycle.
- R11: `ack_done` and `stat_done` pulse exactly one cycle after the accepted strobe and at no other time. After reset, all registered outputs are zero.
- R12: A status read that arrives in the same cycle as an acknowledge is ignored: no clear, no `mst_rsel_isr` and no `stat_done`. The acknowledge is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_pend | input | 1 | Primary core has a pending line |
| mst_line | input | 3 | Primary core's highest pending line |
| mst_base | input | 8 | Primary core vector base |
| slv_pend | input | 1 | Secondary core has a pending line |
| slv_line | input | 3 | Secondary core's highest pending line |
| slv_base | input | 8 | Secondary core vector base |
| cpu_ack | input | 1 | CPU acknowledge strobe, one cycle |
| stat_rd | input | 1 | Status read strobe, one cycle |
| cpu_int | output | 1 | Interrupt request to the CPU |
| casc_req | output | 1 | Pulse into primary core line 2 |
| mst_ack | output | 1 | Set in-service in primary core |
| mst_ack_line | output | 3 | Line for mst_ack |
| slv_ack | output | 1 | Set in-service in secondary core |
| slv_ack_line | output | 3 | Line for slv_ack |
| mst_clr | output | 1 | Clear request and in-service bits in primary core |
| mst_clr_line | output | 3 | Line for mst_clr |
| slv_clr | output | 1 | Clear request and in-service bits in secondary core |
| slv_clr_line | output | 3 | Line for slv_clr |
| mst_rsel_isr | output | 1 | Switch primary core read selection to in-service |
| ack_done | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Acknowledge vector |
| ack_line | output | 4 | Acknowledged line, 0 to 15 |
| stat_done | output | 1 | Status result valid |
| stat_line | output | 4 | Status result line, 0 to 15 |

## Verification
The core-facing strobes are combinational, so a wrong cascade decision shows in the same cycle as the strobe: an acknowledge or clear is missing, or goes to the wrong core. A wrong stored result (a spurious substitution not made, a vector taken from the wrong base, or a missing +8 offset) shows one edge later on the vector and line outputs. A stuck or doubled cascade pulse shows within two cycles of the secondary request rising.

// File: rtl/cic_pkg.sv
package cic_pkg;
   // Which core a result refers to
   typedef enum logic {
      CIC_SRC_PRI = 1'b0,
      CIC_SRC_SEC = 1'b1
   } cic_src_e;
endpackage

// File: rtl/cic_line_pick.sv
// Effective line of one core: the reported line, or the spurious line if none.
module cic_line_pick #(
   parameter int LW        = 3,
   parameter int SPUR_LINE = 7
) (
   input  logic          pend,
   input  logic [LW-1:0] line,
   output logic [LW-1:0] eff
);
   localparam logic [LW-1:0] SPUR = LW'(SPUR_LINE);
   assign eff = pend ? line : SPUR;
endmodule

// File: rtl/cic_vec_form.sv
// Vector from base and line: either added or merged into the low bits.
module cic_vec_form #(
   parameter int VEC_W    = 8,
   parameter int LW       = 3,
   parameter bit ADD_MODE = 1'b1
) (
   input  logic [VEC_W-1:0] base,
   input  logic [LW-1:0]    line,
   output logic [VEC_W-1:0] vec
);
   localparam int PAD = VEC_W - LW;
   logic [VEC_W-1:0] line_x;
   assign line_x = {{PAD{1'b0}}, line};
   generate
      if (ADD_MODE) begin : g_add
         assign vec = base + line_x;
      end else begin : g_or
         assign vec = base | line_x;
      end
   endgenerate
endmodule

// File: rtl/cic_casc_pulse.sv
// Alternating high/low pulse into primary line 2 while the secondary has a request.
module cic_casc_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_pend,
   output logic pulse
);
   logic pulse_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= sec_pend & ~pulse_q;
   end
   assign pulse = pulse_q;
endmodule

// File: rtl/cic_cascade_ack.sv
module cic_cascade_ack #(
   parameter int LINES     = 8,
   parameter int VEC_W     = 8,
   parameter int CASC_LINE = 2,
   parameter int SPUR_LINE = 7,
   parameter bit VEC_ADD   = 1'b1,
   localparam int LW       = $clog2(LINES),
   localparam int GW       = LW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mst_pend,
   input  logic [LW-1:0]    mst_line,
   input  logic [VEC_W-1:0] mst_base,
   input  logic             slv_pend,
   input  logic [LW-1:0]    slv_line,
   input  logic [VEC_W-1:0] slv_base,
   input  logic             cpu_ack,
   input  logic             stat_rd,
   output logic             cpu_int,
   output logic             casc_req,
   output logic             mst_ack,
   output logic [LW-1:0]    mst_ack_line,
   output logic             slv_ack,
   output logic [LW-1:0]    slv_ack_line,
   output logic             mst_clr,
   output logic [LW-1:0]    mst_clr_line,
   output logic             slv_clr,
   output logic [LW-1:0]    slv_clr_line,
   output logic             mst_rsel_isr,
   output logic             ack_done,
   output logic [VEC_W-1:0] ack_vec,
   output logic [GW-1:0]    ack_line,
   output logic             stat_done,
   output logic [GW-1:0]    stat_line
);
   import cic_pkg::*;

   localparam logic [LW-1:0] CASC = LW'(CASC_LINE);

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two, at least 2");
      end
      if (CASC_LINE >= LINES || SPUR_LINE >= LINES) begin : g_bad_line_no
         $error("CASC_LINE and SPUR_LINE must be below LINES");
      end
      if (VEC_W < LW) begin : g_bad_vec
         $error("VEC_W must hold a line number");
      end
   endgenerate

   // effective lines with spurious substitution
   logic [LW-1:0] pri_eff, sec_eff;
   cic_line_pick #(.LW(LW), .SPUR_LINE(SPUR_LINE)) u_pick_pri (
      .pend(mst_pend), .line(mst_line), .eff(pri_eff));
   cic_line_pick #(.LW(LW), .SPUR_LINE(SPUR_LINE)) u_pick_sec (
      .pend(slv_pend), .line(slv_line), .eff(sec_eff));

   // cascade request pulse
   cic_casc_pulse u_casc (.clk(clk), .rst_n(rst_n), .sec_pend(slv_pend), .pulse(casc_req));

   assign cpu_int = mst_pend;

   // source selection shared by acknowledge and status read
   cic_src_e src;
   assign src = (mst_pend && mst_line == CASC) ? CIC_SRC_SEC : CIC_SRC_PRI;

   logic [GW-1:0] comb_line;
   assign comb_line = (src == CIC_SRC_SEC) ? {1'b1, sec_eff} : {1'b0, pri_eff};

   logic [VEC_W-1:0] pri_vec, sec_vec;
   cic_vec_form #(.VEC_W(VEC_W), .LW(LW), .ADD_MODE(VEC_ADD)) u_vec_pri (
      .base(mst_base), .line(pri_eff), .vec(pri_vec));
   cic_vec_form #(.VEC_W(VEC_W), .LW(LW), .ADD_MODE(VEC_ADD)) u_vec_sec (
      .base(slv_base), .line(sec_eff), .vec(sec_vec));

   // acknowledge strobes to the cores
   assign mst_ack      = cpu_ack & mst_pend;
   assign mst_ack_line = mst_line;
   assign slv_ack      = cpu_ack & (src == CIC_SRC_SEC) & slv_pend;
   assign slv_ack_line = slv_line;

   // status read: acknowledge has priority
   logic stat_go;
   assign stat_go      = stat_rd & ~cpu_ack;
   assign mst_clr      = stat_go & mst_pend;
   assign mst_clr_line = mst_line;
   assign slv_clr      = stat_go & (src == CIC_SRC_SEC) & slv_pend;
   assign slv_clr_line = slv_line;
   assign mst_rsel_isr = stat_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_done  <= 1'b0;
         ack_vec   <= '0;
         ack_line  <= '0;
         stat_done <= 1'b0;
         stat_line <= '0;
      end else begin
         ack_done  <= cpu_ack;
         stat_done <= stat_go;
         if (cpu_ack) begin
            ack_line <= comb_line;
            ack_vec  <= (src == CIC_SRC_SEC) ? sec_vec : pri_vec;
         end
         if (stat_go) stat_line <= comb_line;
      end
   end
endmodule

// File: rtl/cic_cascade_ack_chk.sv
module cic_cascade_ack_chk #(
   parameter int LW        = 3,
   parameter int GW        = 4,
   parameter int CASC_LINE = 2,
   parameter int SPUR_LINE = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mst_pend,
   input logic [LW-1:0] mst_line,
   input logic          slv_pend,
   input logic          cpu_ack,
   input logic          stat_rd,
   input logic          cpu_int,
   input logic          casc_req,
   input logic          mst_ack,
   input logic [LW-1:0] mst_ack_line,
   input logic          slv_ack,
   input logic          mst_rsel_isr,
   input logic          ack_done,
   input logic [GW-1:0] ack_line,
   input logic          stat_done
);
   localparam logic [GW-1:0] SPUR_G = GW'(SPUR_LINE);
   localparam logic [LW-1:0] CASC   = LW'(CASC_LINE);

   a_r1_casc_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      casc_req |=> !casc_req);
   a_r1_casc_needs_sec: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(casc_req) |-> $past(slv_pend));
   a_r2_int_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int == mst_pend);
   a_r3_spurious_pri: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !mst_pend) |=> (ack_done && ack_line == SPUR_G));
   a_r5_sec_ack_via_casc: assert property (@(posedge clk) disable iff (!rst_n)
      slv_ack |-> (mst_ack && mst_ack_line == CASC));
   a_r11_ack_done_after: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> ack_done);
   a_r11_ack_done_only: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ack |=> !ack_done);
   a_r10_rsel_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      mst_rsel_isr |=> stat_done);
   a_r12_ack_blocks_stat: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && stat_rd) |=> !stat_done);
endmodule

bind cic_cascade_ack cic_cascade_ack_chk #(
   .LW(LW), .GW(GW), .CASC_LINE(CASC_LINE), .SPUR_LINE(SPUR_LINE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mst_pend(mst_pend), .mst_line(mst_line),
   .slv_pend(slv_pend), .cpu_ack(cpu_ack), .stat_rd(stat_rd), .cpu_int(cpu_int),
   .casc_req(casc_req), .mst_ack(mst_ack), .mst_ack_line(mst_ack_line),
   .slv_ack(slv_ack), .mst_rsel_isr(mst_rsel_isr), .ack_done(ack_done),
   .ack_line(ack_line), .stat_done(stat_done)
);

// File: tb/cic_cascade_ack_bench.sv
module cic_cascade_ack_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mst_pend = 1'b0, slv_pend = 1'b0;
   logic [2:0] mst_line = '0, slv_line = '0;
   logic [7:0] mst_base = 8'h20, slv_base = 8'h70;
   logic       cpu_ack = 1'b0, stat_rd = 1'b0;
   logic       cpu_int, casc_req, mst_ack, slv_ack, mst_clr, slv_clr, mst_rsel_isr;
   logic [2:0] mst_ack_line, slv_ack_line, mst_clr_line, slv_clr_line;
   logic       ack_done, stat_done;
   logic [7:0] ack_vec;
   logic [3:0] ack_line, stat_line;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   cic_cascade_ack u_cic_cascade_ack (
      .clk(clk), .rst_n(rst_n), .mst_pend(mst_pend), .mst_line(mst_line),
      .mst_base(mst_base), .slv_pend(slv_pend), .slv_line(slv_line),
      .slv_base(slv_base), .cpu_ack(cpu_ack), .stat_rd(stat_rd),
      .cpu_int(cpu_int), .casc_req(casc_req), .mst_ack(mst_ack),
      .mst_ack_line(mst_ack_line), .slv_ack(slv_ack), .slv_ack_line(slv_ack_line),
      .mst_clr(mst_clr), .mst_clr_line(mst_clr_line), .slv_clr(slv_clr),
      .slv_clr_line(slv_clr_line), .mst_rsel_isr(mst_rsel_isr),
      .ack_done(ack_done), .ack_vec(ack_vec), .ack_line(ack_line),
      .stat_done(stat_done), .stat_line(stat_line));

   typedef struct packed {
      logic [7:0] vec;
      logic [3:0] line;
      logic [7:0] req;
   } exp_t;

   exp_t ackq[$];
   exp_t statq[$];

   task automatic check(input bit ok, input int req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Driver: acknowledge with given core state; checks core strobes, queues result
   task automatic do_ack(input bit mp, input int ml, input bit sp, input int sl,
                         input bit also_stat, input int req);
      bit casc;
      exp_t e;
      @(negedge clk);
      mst_pend = mp; mst_line = 3'(ml); slv_pend = sp; slv_line = 3'(sl);
      cpu_ack = 1'b1; stat_rd = also_stat;
      #1;
      casc = mp && ml == 2;
      check(mst_ack == mp, req, mst_ack, mp);
      if (mp) check(mst_ack_line == 3'(ml), req, mst_ack_line, ml);
      check(slv_ack == (casc && sp), req, slv_ack, casc && sp);
      if (casc && sp) check(slv_ack_line == 3'(sl), req, slv_ack_line, sl);
      if (also_stat) begin // R12: status read ignored
         check(!mst_rsel_isr && !mst_clr && !slv_clr, 12, {mst_rsel_isr, mst_clr, slv_clr}, 0);
      end
      if (!mp)       begin e.line = 4'd7;            e.vec = mst_base + 8'd7; end
      else if (!casc) begin e.line = 4'(ml);          e.vec = mst_base + 8'(ml); end
      else if (sp)   begin e.line = 4'(sl + 8);      e.vec = slv_base + 8'(sl); end
      else           begin e.line = 4'd15;           e.vec = slv_base + 8'd7; end
      e.req = 8'(req);
      ackq.push_back(e);
      @(negedge clk);
      cpu_ack = 1'b0; stat_rd = 1'b0;
   endtask

   // Driver: status read
   task automatic do_stat(input bit mp, input int ml, input bit sp, input int sl, input int req);
      bit casc;
      exp_t e;
      @(negedge clk);
      mst_pend = mp; mst_line = 3'(ml); slv_pend = sp; slv_line = 3'(sl);
      stat_rd = 1'b1;
      #1;
      casc = mp && ml == 2;
      check(mst_rsel_isr == 1'b1, 10, mst_rsel_isr, 1);  // R10
      check(mst_clr == mp, req, mst_clr, mp);
      if (mp) check(mst_clr_line == 3'(ml), req, mst_clr_line, ml);
      check(slv_clr == (casc && sp), req, slv_clr, casc && sp);
      if (casc && sp) check(slv_clr_line == 3'(sl), req, slv_clr_line, sl);
      if (!mp)        e.line = 4'd7;
      else if (!casc) e.line = 4'(ml);
      else if (sp)    e.line = 4'(sl + 8);
      else            e.line = 4'd15;
      e.vec = '0;
      e.req = 8'(req);
      statq.push_back(e);
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   // Monitor: pops expected items when results appear (R11 covers stray pulses)
   always begin
      exp_t e;
      @(posedge clk);
      #2;
      if (rst_n && ack_done) begin
         if (ackq.size() == 0) check(1'b0, 11, 1, 0);
         else begin
            e = ackq.pop_front();
            check(ack_line == e.line, int'(e.req), ack_line, e.line);
            check(ack_vec == e.vec, int'(e.req), ack_vec, e.vec);
         end
      end
      if (rst_n && stat_done) begin
         if (statq.size() == 0) check(1'b0, 11, 1, 0);
         else begin
            e = statq.pop_front();
            check(stat_line == e.line, int'(e.req), stat_line, e.line);
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         check(1'b0, 0, 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check({ack_done, stat_done, ack_vec, ack_line, stat_line, casc_req} == '0, 11,
            {ack_done, stat_done, casc_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: interrupt output follows primary pending
      mst_pend = 1'b1; #1; check(cpu_int == 1'b1, 2, cpu_int, 1);
      mst_pend = 1'b0; #1; check(cpu_int == 1'b0, 2, cpu_int, 0);
      // R1: cascade pulse pattern 1,0,1,0 then quiet
      @(negedge clk); slv_pend = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(casc_req == ((i % 2) == 0), 1, casc_req, (i % 2) == 0);
      end
      slv_pend = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(casc_req == 1'b0, 1, casc_req, 0);
      end
      do_ack(1'b0, 0, 1'b0, 0, 1'b0, 3);  // R3 spurious primary
      do_ack(1'b1, 5, 1'b0, 0, 1'b0, 4);  // R4
      do_ack(1'b1, 0, 1'b1, 4, 1'b0, 4);  // R4 secondary ignored on non-cascade line
      do_ack(1'b1, 2, 1'b1, 3, 1'b0, 5);  // R5
      do_ack(1'b1, 2, 1'b1, 0, 1'b0, 5);  // R5
      do_ack(1'b1, 2, 1'b0, 0, 1'b0, 6);  // R6 spurious secondary
      do_stat(1'b1, 4, 1'b0, 0, 7);       // R7
      do_stat(1'b1, 7, 1'b1, 1, 7);       // R7
      do_stat(1'b0, 0, 1'b0, 0, 8);       // R8
      do_stat(1'b1, 2, 1'b1, 6, 9);       // R9
      do_stat(1'b1, 2, 1'b0, 0, 9);       // R9 empty secondary
      do_ack(1'b1, 6, 1'b0, 0, 1'b1, 12); // R12 ack wins over status read
      // R2: after acknowledge, core drops its request
      @(negedge clk); mst_pend = 1'b0; #1; check(cpu_int == 1'b0, 2, cpu_int, 0);
      repeat (3) @(negedge clk);
      check(ackq.size() == 0, 11, ackq.size(), 0);
      check(statq.size() == 0, 11, statq.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule